// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Receiver

The block turns an asynchronous serial line into bytes. The line is first passed through a synchroniser. A falling edge then starts a character. The receiver confirms the start bit half a bit period later. It then collects eight data bits, least significant bit first, and checks one or two stop bits, as chosen by a configuration input. Timing comes from an oversampling tick input that pulses once every 1/16 of a bit period. The receiver does not generate baud rates itself.

A finished character moves from the shift register into a separate holding register. This frees the shift register for the next character while the host reads the previous one. The host sees three status bits:

- a data-ready flag, cleared by a read strobe;
- a framing-error flag;
- an overrun flag.

The two error flags stay set until a clear strobe arrives. A single interrupt line pulses for one clock whenever a character lands in the holding register or a framing error is detected. After a framing error the receiver goes back to hunting for a start bit on its own.

Top module: `serial_rx_dbuf`

## Requirements
- R1: After reset, `data_o` is 0, `ready_o`, `frame_err_o`, `overrun_o` and `irq_o` are 0, and the receiver is idle.
- R2: A character starts only on a high-to-low transition of the synchronised line. The start bit is accepted only if the line is still low at the 8th tick after the edge. A shorter low pulse leaves every output unchanged and raises no interrupt.
- R3: Each data bit is sampled once, at the middle of its 16-tick period. The first data bit after the start bit becomes bit 0 of `data_o` and the eighth becomes bit 7.
- R4: When the required stop bit(s) are high, the received byte is copied to `data_o` and `ready_o` becomes 1.
- R5: When `two_stop_i` is 1, both stop bits must be high. A low second stop bit is a framing error and no byte is loaded.
- R6: A low stop bit sets `frame_err_o`. It leaves `data_o` and `ready_o` unchanged.
- R7: After a framing error, the next correctly formed character is received without any outside action.
- R8: A one-cycle `rd_i` strobe clears `ready_o`. `data_o` keeps its value.
- R9: Loading a byte while `ready_o` is 1 and `rd_i` is 0 sets `overrun_o`, and `data_o` takes the new byte.
- R10: `frame_err_o` and `overrun_o` stay set until a `clr_err_i` strobe or reset. `clr_err_i` does not alter `ready_o` or `data_o`.
- R11: `irq_o` is high for exactly one clock for each loaded byte and for each framing error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Oversampling tick, 16 per bit period |
| rx_i | input | 1 | Asynchronous serial line, idle high |
| two_stop_i | input | 1 | 1 = two stop bits required, 0 = one |
| rd_i | input | 1 | Host read strobe, clears data-ready |
| clr_err_i | input | 1 | Clears framing-error and overrun flags |
| data_o | output | 8 | Receive holding register |
| ready_o | output | 1 | Data-ready flag |
| frame_err_o | output | 1 | Sticky framing-error flag |
| overrun_o | output | 1 | Sticky overrun flag |
| irq_o | output | 1 | One-clock interrupt pulse |

## Verification
The bench builds the receiver with its default parameters: an 8-bit character, 16 ticks per bit and a two-stage synchroniser. It drives one oversampling tick every four clocks. Each bit therefore spans 64 clocks, which leaves the mid-bit sample point far from any bit edge. This spacing makes the half-bit start check reachable with a three-tick glitch. It also exercises single-bit patterns at both ends of the byte, both stop-bit settings, and back-to-back characters with no read in between, which produce an overrun.

// File: rtl/rx_pkg.sv
package rx_pkg;
    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_e;
endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o,
    output logic fall_o
);
    typedef struct packed {
        logic [STAGES-1:0] pipe;
        logic              prev;
    } sync_regs_t;

    sync_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.pipe = {r_q.pipe[STAGES-2:0], line_i};
        r_d.prev = r_q.pipe[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign line_o = r_q.pipe[STAGES-1];
    assign fall_o = r_q.prev & ~r_q.pipe[STAGES-1];
endmodule

// File: rtl/rx_framer.sv
module rx_framer
    import rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              line_i,
    input  logic              fall_i,
    input  logic              two_stop_i,
    output logic [DATA_W-1:0] byte_o,
    output logic              done_o,
    output logic              ferr_o
);
    localparam int CNT_W = $clog2(OSR);
    localparam int BIT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OSR / 2 - 1);
    localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(OSR - 1);
    localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(DATA_W - 1);

    typedef struct packed {
        rx_state_e         state;
        logic [CNT_W-1:0]  cnt;
        logic [BIT_W-1:0]  nbit;
        logic              second;
        logic [DATA_W-1:0] shreg;
        logic              done;
        logic              ferr;
    } frm_regs_t;

    frm_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.ferr = 1'b0;
        unique case (r_q.state)
            RX_IDLE: begin
                if (fall_i) begin
                    r_d.state = RX_START;
                    r_d.cnt   = '0;
                end
            end
            RX_START: begin
                if (tick_i) begin
                    if (r_q.cnt == HALF_LAST) begin
                        r_d.cnt = '0;
                        if (!line_i) begin
                            r_d.state = RX_DATA;
                            r_d.nbit  = '0;
                        end else begin
                            r_d.state = RX_IDLE;
                        end
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end
            RX_DATA: begin
                if (tick_i) begin
                    if (r_q.cnt == FULL_LAST) begin
                        r_d.cnt   = '0;
                        r_d.shreg = {line_i, r_q.shreg[DATA_W-1:1]};
                        if (r_q.nbit == LAST_BIT) begin
                            r_d.state  = RX_STOP;
                            r_d.second = 1'b0;
                        end else begin
                            r_d.nbit = r_q.nbit + 1'b1;
                        end
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end
            RX_STOP: begin
                if (tick_i) begin
                    if (r_q.cnt == FULL_LAST) begin
                        r_d.cnt = '0;
                        if (!line_i) begin
                            r_d.ferr  = 1'b1;
                            r_d.state = RX_IDLE;
                        end else if (two_stop_i && !r_q.second) begin
                            r_d.second = 1'b1;
                        end else begin
                            r_d.done  = 1'b1;
                            r_d.state = RX_IDLE;
                        end
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end
            default: r_d.state = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: RX_IDLE, cnt: '0, nbit: '0, second: 1'b0,
                     shreg: '0, done: 1'b0, ferr: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign byte_o = r_q.shreg;
    assign done_o = r_q.done;
    assign ferr_o = r_q.ferr;
endmodule

// File: rtl/rx_holding.sv
module rx_holding #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              ferr_i,
    input  logic [DATA_W-1:0] byte_i,
    input  logic              rd_i,
    input  logic              clr_i,
    output logic [DATA_W-1:0] data_o,
    output logic              ready_o,
    output logic              ferr_o,
    output logic              ovr_o,
    output logic              irq_o
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              ready;
        logic              ferr;
        logic              ovr;
        logic              irq;
    } hold_regs_t;

    hold_regs_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        r_d.irq = load_i | ferr_i;
        if (clr_i) begin
            r_d.ferr = 1'b0;
            r_d.ovr  = 1'b0;
        end
        if (ferr_i) begin
            r_d.ferr = 1'b1;
        end
        if (load_i) begin
            r_d.data  = byte_i;
            r_d.ready = 1'b1;
            if (r_q.ready && !rd_i) begin
                r_d.ovr = 1'b1;
            end
        end else if (rd_i) begin
            r_d.ready = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign data_o  = r_q.data;
    assign ready_o = r_q.ready;
    assign ferr_o  = r_q.ferr;
    assign ovr_o   = r_q.ovr;
    assign irq_o   = r_q.irq;
endmodule

// File: rtl/serial_rx_dbuf.sv
module serial_rx_dbuf #(
    parameter int DATA_W      = 8,
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              rx_i,
    input  logic              two_stop_i,
    input  logic              rd_i,
    input  logic              clr_err_i,
    output logic [DATA_W-1:0] data_o,
    output logic              ready_o,
    output logic              frame_err_o,
    output logic              overrun_o,
    output logic              irq_o
);
    logic              line_s;
    logic              fall_s;
    logic [DATA_W-1:0] shifted;
    logic              done_s;
    logic              ferr_s;

    rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (rx_i),
        .line_o (line_s),
        .fall_o (fall_s)
    );

    rx_framer #(.DATA_W(DATA_W), .OSR(OSR)) u_frm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .line_i     (line_s),
        .fall_i     (fall_s),
        .two_stop_i (two_stop_i),
        .byte_o     (shifted),
        .done_o     (done_s),
        .ferr_o     (ferr_s)
    );

    rx_holding #(.DATA_W(DATA_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (done_s),
        .ferr_i  (ferr_s),
        .byte_i  (shifted),
        .rd_i    (rd_i),
        .clr_i   (clr_err_i),
        .data_o  (data_o),
        .ready_o (ready_o),
        .ferr_o  (frame_err_o),
        .ovr_o   (overrun_o),
        .irq_o   (irq_o)
    );
endmodule

// File: rtl/serial_rx_dbuf_chk.sv
module serial_rx_dbuf_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_i,
    input logic              clr_err_i,
    input logic [DATA_W-1:0] data_o,
    input logic              ready_o,
    input logic              frame_err_o,
    input logic              overrun_o,
    input logic              irq_o
);
    // R11
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    // R4
    ready_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> irq_o);

    // R6
    ferr_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_err_o) |-> irq_o);

    // R9
    ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun_o) |-> ($past(ready_o) && irq_o && !$past(rd_i)));

    // R8
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(data_o) |-> irq_o);

    // R10
    clear_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_err_i |=> (!overrun_o || irq_o));

    // R10
    clear_ferr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_err_i |=> (!frame_err_o || irq_o));

    // R10
    sticky_ferr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_err_o) |-> $past(clr_err_i));
endmodule

bind serial_rx_dbuf serial_rx_dbuf_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_i        (rd_i),
    .clr_err_i   (clr_err_i),
    .data_o      (data_o),
    .ready_o     (ready_o),
    .frame_err_o (frame_err_o),
    .overrun_o   (overrun_o),
    .irq_o       (irq_o)
);

// File: tb/serial_rx_dbuf_test.sv
`timescale 1ns/1ps
module serial_rx_dbuf_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       rx = 1'b1;
    logic       two_stop = 1'b0;
    logic       rd = 1'b0;
    logic       clr = 1'b0;
    logic [7:0] data;
    logic       ready, ferr, ovr, irq;

    int n_checks = 0;
    int n_fail = 0;
    int irq_pulses = 0;
    int irq_high = 0;
    logic irq_prev = 1'b0;
    logic [1:0] tdiv = 2'd0;
    bit finished = 0;

    always #10 clk = ~clk;

    always @(posedge clk) begin
        tdiv <= tdiv + 2'd1;
        tick <= (tdiv == 2'd3);
        irq_prev <= irq;
        if (irq) irq_high <= irq_high + 1;
        if (irq && !irq_prev) irq_pulses <= irq_pulses + 1;
    end

    serial_rx_dbuf uut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .rx_i(rx),
        .two_stop_i(two_stop), .rd_i(rd), .clr_err_i(clr),
        .data_o(data), .ready_o(ready), .frame_err_o(ferr),
        .overrun_o(ovr), .irq_o(irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            while (tick !== 1'b1) @(posedge clk);
        end
    endtask

    task automatic drive_bit(logic v);
        @(negedge clk) rx = v;
        wait_ticks(16);
    endtask

    task automatic send(logic [7:0] b, logic s1, logic s2, bit use2);
        drive_bit(1'b0);
        for (int i = 0; i < 8; i++) drive_bit(b[i]);
        drive_bit(s1);
        if (use2) drive_bit(s2);
        @(negedge clk) rx = 1'b1;
        wait_ticks(20);
        @(negedge clk);
    endtask

    task automatic strobe_rd();
        @(negedge clk) rd = 1'b1;
        @(negedge clk) rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic strobe_clr();
        @(negedge clk) clr = 1'b1;
        @(negedge clk) clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 data", data, 0);
        check("R1 ready", ready, 0);
        check("R1 ferr", ferr, 0);
        check("R1 ovr", ovr, 0);
        check("R1 irq", irq, 0);
    endtask

    task automatic t_basic();
        int p0 = irq_pulses, h0 = irq_high;
        send(8'hA5, 1'b1, 1'b1, 0);
        check("R4 data", data, 8'hA5);
        check("R4 ready", ready, 1);
        check("R11 pulses", irq_pulses - p0, 1);
        check("R11 width", irq_high - h0, 1);
        strobe_rd();
        check("R8 ready clear", ready, 0);
        check("R8 data kept", data, 8'hA5);
    endtask

    task automatic t_order();
        send(8'h01, 1'b1, 1'b1, 0);
        check("R3 lsb", data, 8'h01);
        strobe_rd();
        send(8'h80, 1'b1, 1'b1, 0);
        check("R3 msb", data, 8'h80);
        strobe_rd();
    endtask

    task automatic t_glitch();
        int p0 = irq_pulses;
        @(negedge clk) rx = 1'b0;
        wait_ticks(3);
        @(negedge clk) rx = 1'b1;
        wait_ticks(40);
        @(negedge clk);
        check("R2 no irq", irq_pulses - p0, 0);
        check("R2 no ready", ready, 0);
        check("R2 no ferr", ferr, 0);
        check("R2 data kept", data, 8'h80);
        send(8'h3C, 1'b1, 1'b1, 0);
        check("R2 after glitch", data, 8'h3C);
        strobe_rd();
    endtask

    task automatic t_frame();
        int p0 = irq_pulses;
        send(8'h55, 1'b0, 1'b1, 0);
        check("R6 ferr", ferr, 1);
        check("R6 data kept", data, 8'h3C);
        check("R6 ready kept", ready, 0);
        check("R11 ferr irq", irq_pulses - p0, 1);
        send(8'h96, 1'b1, 1'b1, 0);
        check("R7 resume data", data, 8'h96);
        check("R7 resume ready", ready, 1);
        check("R10 ferr sticky", ferr, 1);
        strobe_rd();
        strobe_clr();
        check("R10 ferr cleared", ferr, 0);
    endtask

    task automatic t_two_stop();
        two_stop = 1'b1;
        send(8'h5A, 1'b1, 1'b1, 1);
        check("R5 good two stop", data, 8'h5A);
        check("R5 no ferr", ferr, 0);
        strobe_rd();
        send(8'h11, 1'b1, 1'b0, 1);
        check("R5 second stop low", ferr, 1);
        check("R5 data kept", data, 8'h5A);
        check("R5 ready kept", ready, 0);
        two_stop = 1'b0;
        strobe_clr();
    endtask

    task automatic t_overrun();
        send(8'h12, 1'b1, 1'b1, 0);
        check("R9 no ovr yet", ovr, 0);
        send(8'h34, 1'b1, 1'b1, 0);
        check("R9 ovr", ovr, 1);
        check("R9 new data", data, 8'h34);
        strobe_clr();
        check("R10 ovr cleared", ovr, 0);
        check("R10 ready kept", ready, 1);
        check("R10 data kept", data, 8'h34);
        strobe_rd();
        check("R8 ready after ovr", ready, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_basic();
        t_order();
        t_glitch();
        t_frame();
        t_two_stop();
        t_overrun();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule